// File: doc/BRIEF.md
# Countdown Watchdog with Register Access

This block is a system watchdog. Software programs a timeout as a number of 10 ms ticks through a small register port, then sets the run bit and the reload trigger together to start the countdown. An internal divider turns the core clock into a one-cycle tick strobe every 10 ms. Each tick lowers the live counter by one. Software keeps the system alive by writing the reload trigger again before the counter runs out. Reading the count register gives the ticks that remain.

When the counter reaches zero while the run bit is set, the block latches a warning status bit and drives a system reset request for a fixed number of clock cycles. It also raises a non-maskable interrupt line for as long as the warning bit and the interrupt-enable bit are both set. The register port is a simple single-cycle request interface with byte enables on a 16-bit data path. Read data returns one cycle after the request. The port accepts a request on every cycle and never applies back-pressure, so it has no ready signal.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the reset request and interrupt outputs are low, and both the count register (byte offset 0x10) and the control register (byte offset 0x16) read as zero.
- R2: A write to the count register always sets the programmed timeout. It also loads the live counter only when the run bit is clear. While the timer runs, the live count is unaffected until the next reload.
- R3: A control write with run (bit 0) and reload (bit 2) both set loads the programmed timeout. The first decrement follows one tick period (CLK_HZ/TICK_HZ cycles) after that write, and each further decrement follows one period later.
- R4: A reload while running restores the programmed timeout and restarts the tick divider, so the next decrement is again a full tick period away.
- R5: A control write that clears the run bit freezes the live counter and stops expiry. The interrupt-enable bit keeps the value written in the same byte.
- R6: The control register reads back run in bit 0, interrupt enable in bit 3 and the warning flag in bit 7. The reload bit and all other bits read as zero.
- R7: One cycle after the running counter reaches zero, the warning flag sets and the reset request goes high for exactly RST_CYCLES cycles. Expiry happens once per load. A timeout of 1 expires within one tick period plus one cycle of the reload.
- R8: The interrupt output is high exactly while the warning flag and the interrupt-enable bit (bit 3) are both set.
- R9: Writing 1 to bit 7 of the control register clears the warning flag. Writing 0 to bit 7 leaves it set.
- R10: A control write with the reload bit at 0 neither reloads the counter nor restarts the divider.
- R11: Read data is valid in the cycle after a read request, marked by the read-valid output. Byte enable 0 writes the low byte and byte enable 1 writes the high byte of the count register. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at CLK_HZ |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address (bit 0 ignored, halfword lanes) |
| bus_be | input | 2 | Byte enables for writes: bit 0 low lane, bit 1 high lane |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read request |
| rst_req_o | output | 1 | System reset request pulse on expiry |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
Each register write takes effect at the clock edge that samples it. The first decrement after a load lands exactly one tick period later. Expiry follows one cycle after the counter reaches zero, and the reset request then stays high for RST_CYCLES cycles. The bench drives every access at a falling edge and counts whole cycles from the sampling edge of the load before it samples. A read issued right after edge e returns the state left by edge e. With the reduced tick period used in the bench, each expected count and each rise or fall of the reset request is checked in its own cycle, including the cycle just before it, and the interrupt line is checked right after the control write that gates it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h16;

  localparam int unsigned CTL_RUN    = 0;
  localparam int unsigned CTL_RELOAD = 2;
  localparam int unsigned CTL_NMIEN  = 3;
  localparam int unsigned CTL_WARN   = 7;

  function automatic logic [7:0] pack_ctl(input logic run, input logic nmi_en, input logic warn);
    logic [7:0] v;
    v = '0;
    v[CTL_RUN]   = run;
    v[CTL_NMIEN] = nmi_en;
    v[CTL_WARN]  = warn;
    return v;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = run && (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart || !run || tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             fire,
  output logic             rst_req
);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);
  localparam logic [RW-1:0] RST_LEN = RW'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic [RW-1:0]    hold_q;

  assign fire    = run && !load && !fired_q && (cnt_q == '0);
  assign count   = cnt_q;
  assign rst_req = (hold_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
    end else if (load) begin
      fired_q <= 1'b0;
    end else if (fire) begin
      fired_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (fire) begin
      hold_q <= RST_LEN;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] live_cnt,
  input  logic              fire,
  output logic              ctl_run,
  output logic              ctl_nmi_en,
  output logic              ctl_warn,
  output logic [DATA_W-1:0] prog_next,
  output logic              load_live,
  output logic              reload,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  logic [DATA_W-1:0] prog_q;
  logic              hit_cnt, hit_ctl, wr_cnt, wr_ctl;
  logic [DATA_W-1:0] rd_mux;

  assign hit_cnt = bus_req && (bus_addr[ADDR_W-1:1] == OFS_COUNT[ADDR_W-1:1]);
  assign hit_ctl = bus_req && (bus_addr[ADDR_W-1:1] == OFS_CTRL[ADDR_W-1:1]);
  assign wr_cnt  = hit_cnt && bus_wr && (|bus_be);
  assign wr_ctl  = hit_ctl && bus_wr && bus_be[0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign prog_next[8*g +: 8] = (wr_cnt && bus_be[g]) ? bus_wdata[8*g +: 8] : prog_q[8*g +: 8];
  end

  assign reload    = wr_ctl && bus_wdata[CTL_RELOAD];
  assign load_live = reload || (wr_cnt && !ctl_run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q     <= '0;
      ctl_run    <= 1'b0;
      ctl_nmi_en <= 1'b0;
    end else begin
      prog_q <= prog_next;
      if (wr_ctl) begin
        ctl_run    <= bus_wdata[CTL_RUN];
        ctl_nmi_en <= bus_wdata[CTL_NMIEN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_warn <= 1'b0;
    end else if (fire) begin
      ctl_warn <= 1'b1;
    end else if (wr_ctl && bus_wdata[CTL_WARN]) begin
      ctl_warn <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cnt) begin
      rd_mux = live_cnt;
    end else if (hit_ctl) begin
      rd_mux[7:0] = pack_ctl(ctl_run, ctl_nmi_en, ctl_warn);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_req && !bus_wr;
      if (bus_req && !bus_wr) begin
        bus_rdata <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned TICK_HZ    = 100,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        rst_req_o,
  output logic        nmi_o
);
  localparam int unsigned TICK_DIV = CLK_HZ / TICK_HZ;

  logic                        ctl_run, ctl_nmi_en, ctl_warn;
  logic [wdog_pkg::DATA_W-1:0] prog_next, live_cnt;
  logic                        load_live, reload, tick, fire;

  wdog_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .live_cnt   (live_cnt),
    .fire       (fire),
    .ctl_run    (ctl_run),
    .ctl_nmi_en (ctl_nmi_en),
    .ctl_warn   (ctl_warn),
    .prog_next  (prog_next),
    .load_live  (load_live),
    .reload     (reload),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  wdog_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_run),
    .restart (reload),
    .tick    (tick)
  );

  wdog_core #(.CNT_W(wdog_pkg::DATA_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_run),
    .tick     (tick),
    .load     (load_live),
    .load_val (prog_next),
    .count    (live_cnt),
    .fire     (fire),
    .rst_req  (rst_req_o)
  );

  assign nmi_o = ctl_warn && ctl_nmi_en;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned RST_CYCLES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        tick,
  input logic        load,
  input logic [15:0] live_cnt,
  input logic        fire,
  input logic        warn,
  input logic        nmi_en,
  input logic        nmi,
  input logic        rst_req
);
  localparam int unsigned LW = $clog2(RST_CYCLES + 2);

  logic [LW-1:0] high_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_len <= '0;
    end else if (fire || !rst_req) begin
      high_len <= '0;
    end else if (high_len <= LW'(RST_CYCLES)) begin
      high_len <= high_len + 1'b1;
    end
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) tick |-> run); // R3
  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) !load |=> (live_cnt <= $past(live_cnt))); // R3
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !load) |=> $stable(live_cnt)); // R5
  AST_RST_WITH_WARN: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_req) |-> warn); // R7
  AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> (high_len < LW'(RST_CYCLES))); // R7
  AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n) nmi |-> (nmi_en && warn)); // R8
endmodule

bind wdog_timer wdog_timer_chk #(.RST_CYCLES(RST_CYCLES)) u_wdog_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (ctl_run),
  .tick     (tick),
  .load     (load_live),
  .live_cnt (live_cnt),
  .fire     (fire),
  .warn     (ctl_warn),
  .nmi_en   (ctl_nmi_en),
  .nmi      (nmi_o),
  .rst_req  (rst_req_o)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int RSTC       = 4;
  localparam logic [4:0] A_CNT = 5'h10;
  localparam logic [4:0] A_CTL = 5'h16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [4:0]  bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_rvalid, rst_req_o, nmi_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  wdog_timer #(.CLK_HZ(1000), .TICK_HZ(100), .RST_CYCLES(RSTC)) i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .rst_req_o(rst_req_o), .nmi_o(nmi_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  // returns the state left by the edge just before the call
  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic cleanup();
    wr(A_CTL, 2'b01, 16'h0080);
    step(RSTC + 2);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk_eq("R1 rst_req", {15'd0, rst_req_o}, 16'd0);
    chk_eq("R1 nmi", {15'd0, nmi_o}, 16'd0);
    rd(A_CTL, v);
    chk_eq("R1 ctrl", v, 16'h0000);
    chk_eq("R11 rvalid after read", {15'd0, bus_rvalid}, 16'd1);
    rd(A_CNT, v);
    chk_eq("R1 count", v, 16'h0000);
    step(1);
    chk_eq("R11 rvalid idle", {15'd0, bus_rvalid}, 16'd0);
  endtask

  task automatic t_count_stopped();
    logic [15:0] v;
    wr(A_CNT, 2'b11, 16'h1234);
    rd(A_CNT, v);
    chk_eq("R2 stopped write loads live", v, 16'h1234);
    wr(A_CNT, 2'b01, 16'hFFAB);
    rd(A_CNT, v);
    chk_eq("R11 low lane write", v, 16'h12AB);
    wr(A_CNT, 2'b10, 16'h56CD);
    rd(A_CNT, v);
    chk_eq("R11 high lane write", v, 16'h56AB);
    rd(5'h00, v);
    chk_eq("R11 unmapped read", v, 16'h0000);
  endtask

  task automatic t_countdown();
    logic [15:0] v;
    wr(A_CNT, 2'b11, 16'd5);
    wr(A_CTL, 2'b01, 16'h0005);          // edge k
    rd(A_CNT, v);                         // after k
    chk_eq("R3 loaded", v, 16'd5);
    step(8);                              // after k+9
    rd(A_CNT, v);
    chk_eq("R3 no decrement before period", v, 16'd5);
    rd(A_CNT, v);                         // after k+10
    chk_eq("R3 first decrement", v, 16'd4);
    step(9);                              // after k+20
    rd(A_CNT, v);
    chk_eq("R3 second decrement", v, 16'd3);
    cleanup();
  endtask

  task automatic t_running_write();
    logic [15:0] v;
    wr(A_CNT, 2'b11, 16'd50);
    wr(A_CTL, 2'b01, 16'h0005);
    wr(A_CNT, 2'b11, 16'd7);
    rd(A_CNT, v);
    chk_eq("R2 running write leaves live", v, 16'd50);
    wr(A_CTL, 2'b01, 16'h0005);
    rd(A_CNT, v);
    chk_eq("R2 reload takes new timeout", v, 16'd7);
    cleanup();
  endtask

  task automatic t_refresh();
    logic [15:0] v;
    wr(A_CNT, 2'b11, 16'd3);
    wr(A_CTL, 2'b01, 16'h0005);          // edge k
    step(15);                             // after k+15
    wr(A_CTL, 2'b01, 16'h0005);          // edge m = k+16
    rd(A_CNT, v);
    chk_eq("R4 refreshed count", v, 16'd3);
    step(29);                             // after m+30
    chk_eq("R4 no early expiry", {15'd0, rst_req_o}, 16'd0);
    step(1);                              // after m+31
    chk_eq("R4 expiry after full restart", {15'd0, rst_req_o}, 16'd1);
    cleanup();
  endtask

  task automatic t_stop();
    logic [15:0] v;
    wr(A_CNT, 2'b11, 16'd5);
    wr(A_CTL, 2'b01, 16'h000D);          // edge k
    step(11);                             // after k+11, count 4
    wr(A_CTL, 2'b01, 16'h0008);
    step(30);
    rd(A_CNT, v);
    chk_eq("R5 count frozen", v, 16'd4);
    rd(A_CTL, v);
    chk_eq("R5 R6 nmi enable kept, run clear", v, 16'h0008);
    chk_eq("R5 no expiry when stopped", {15'd0, rst_req_o}, 16'd0);
    cleanup();
  endtask

  task automatic t_no_reload();
    logic [15:0] v;
    wr(A_CNT, 2'b11, 16'd5);
    wr(A_CTL, 2'b01, 16'h0005);          // edge k
    step(11);                             // after k+11
    wr(A_CTL, 2'b01, 16'h0001);          // edge k+12
    rd(A_CNT, v);
    chk_eq("R10 reload 0 keeps count", v, 16'd4);
    step(7);                              // after k+20
    rd(A_CNT, v);
    chk_eq("R10 divider not restarted", v, 16'd3);
    cleanup();
  endtask

  task automatic t_expire();
    logic [15:0] v;
    wr(A_CNT, 2'b11, 16'd1);
    wr(A_CTL, 2'b01, 16'h0005);          // edge k
    step(10);                             // after k+10, count 0
    chk_eq("R7 not yet expired", {15'd0, rst_req_o}, 16'd0);
    step(1);                              // after k+11
    chk_eq("R7 reset request rises", {15'd0, rst_req_o}, 16'd1);
    chk_eq("R8 nmi low while disabled", {15'd0, nmi_o}, 16'd0);
    step(RSTC - 1);
    chk_eq("R7 reset request last cycle", {15'd0, rst_req_o}, 16'd1);
    step(1);
    chk_eq("R7 reset request falls", {15'd0, rst_req_o}, 16'd0);
    rd(A_CTL, v);
    chk_eq("R6 R7 warn set, reload reads 0", v, 16'h0081);
    wr(A_CTL, 2'b01, 16'h0009);
    chk_eq("R8 nmi follows enable", {15'd0, nmi_o}, 16'd1);
    rd(A_CTL, v);
    chk_eq("R9 writing 0 keeps warn", v, 16'h0089);
    wr(A_CTL, 2'b01, 16'h0089);
    chk_eq("R8 nmi drops with warn", {15'd0, nmi_o}, 16'd0);
    rd(A_CTL, v);
    chk_eq("R9 warn cleared", v, 16'h0009);
    step(20);
    chk_eq("R7 fires once per load", {15'd0, rst_req_o}, 16'd0);
    rd(A_CTL, v);
    chk_eq("R7 no second warn", v, 16'h0009);
    cleanup();
  endtask

  task automatic t_nmi_expire();
    wr(A_CNT, 2'b11, 16'd1);
    wr(A_CTL, 2'b01, 16'h000D);
    step(11);
    chk_eq("R8 nmi on expiry", {15'd0, nmi_o}, 16'd1);
    chk_eq("R7 reset with nmi", {15'd0, rst_req_o}, 16'd1);
    cleanup();
    chk_eq("R9 nmi cleared via warn", {15'd0, nmi_o}, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_count_stopped();
    t_countdown();
    t_running_write();
    t_refresh();
    t_stop();
    t_no_reload();
    t_expire();
    t_nmi_expire();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule